// File: doc/BRIEF.md
# Virtual-Channel Router Input Stage

This block is the receiving side of one port of a packet router for an on-chip network. Every cycle it may take one flit from the incoming link. Each flit names a virtual channel (VC) and has one of four kinds. A flit that opens a packet must find its VC idle. It marks the VC busy, asks an external combinational route function for an output port, and that port is latched for the rest of the packet. A flit that continues or closes a packet must find its VC busy. A flit that breaks these rules is dropped and an error pulse is raised.

Accepted flits are queued in a per-VC FIFO. A flit only advertises itself as ready for switch allocation after it has spent a configurable number of pipeline stages in the buffer. When the external allocator grants a VC, that VC's head flit is popped. On the following clock edge a credit goes upstream carrying the VC number and a flag that tells whether the VC has become free. A closing flit frees the VC at the moment it is granted. Each virtual network (a group of VCs, found by dividing the VC index by the VCs-per-network parameter) keeps a pair of buffer-write and buffer-read counters. A separate clear input zeroes these counters.

Top module: `vcin_input_unit`

## Requirements
- R1: After synchronous reset every VC is idle and empty (`vc_head_vld_o` all zero), `crd_vld_o` and `proto_err_o` are low, and every statistics counter reads zero.
- R2: The flit kind on `in_type_i` is encoded 0 = opening, 1 = middle, 2 = closing, 3 = single-flit. When an opening or single-flit arrives on an idle VC, `rc_outport_i` (the route for `rc_dest_o`, which mirrors `in_dest_i`) is latched into that VC's field of `vc_outport_o` (VC v at bits v*OP_W upward). The field keeps that value while later flits of the packet arrive, whatever their destination.
- R3: Within a VC, flits leave in the order they were accepted. `vc_head_type_o` and `vc_head_data_o` show the oldest buffered flit, and VCs do not disturb each other when their arrivals are interleaved.
- R4: A flit accepted into an empty VC shows `vc_head_vld_o` in the first cycle after the accepting edge. `vc_head_rdy_o` follows PIPE-1 cycles after that, or in that same first cycle when PIPE = 1.
- R5: A middle or closing flit on an idle VC, or an opening or single-flit on a busy VC, is not buffered and not counted. `proto_err_o` is high for exactly the one cycle after that flit's edge.
- R6: A grant (`sa_gnt_vld_i` with `sa_gnt_vc_i`) pops that VC's head. In the cycle after the grant edge, `crd_vld_o` is high and `crd_vc_o` equals the granted VC. `crd_free_o` is 1 exactly when the popped flit was closing or single-flit. `crd_vld_o` is low after a cycle with no grant.
- R7: Granting a closing or single-flit returns its VC to idle: a later middle flit on it is a protocol error, and a later opening flit is accepted.
- R8: Every accepted flit on VC v adds one to both the write and the read counter of virtual network v / VC_PER_VNET (network n at bits n*CNT_W upward). Other networks' counters do not change.
- R9: `stats_clr_i` zeroes all counters at the next edge and takes priority over an increment in the same cycle. It leaves the buffers and the VC states as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_vld_i | input | 1 | Incoming flit valid |
| in_vc_i | input | VC_W | VC of the incoming flit |
| in_type_i | input | 2 | Flit kind (0 open, 1 middle, 2 close, 3 single) |
| in_dest_i | input | DEST_W | Destination carried by the flit |
| in_data_i | input | DATA_W | Flit payload |
| rc_dest_o | output | DEST_W | Destination presented to the route function |
| rc_outport_i | input | OP_W | Output port returned by the route function |
| vc_head_vld_o | output | NUM_VC | VC holds at least one flit |
| vc_head_rdy_o | output | NUM_VC | VC head flit has finished its pipeline wait |
| vc_outport_o | output | NUM_VC*OP_W | Latched output port per VC |
| vc_head_type_o | output | NUM_VC*2 | Kind of each VC's head flit |
| vc_head_data_o | output | NUM_VC*DATA_W | Payload of each VC's head flit |
| sa_gnt_vld_i | input | 1 | Switch grant valid |
| sa_gnt_vc_i | input | VC_W | Granted VC |
| crd_vld_o | output | 1 | Credit valid |
| crd_vc_o | output | VC_W | VC the credit belongs to |
| crd_free_o | output | 1 | Credit frees the VC |
| proto_err_o | output | 1 | Protocol error pulse |
| stats_clr_i | input | 1 | Zero the statistics counters |
| buf_wr_cnt_o | output | NUM_VNET*CNT_W | Buffer write counters per virtual network |
| buf_rd_cnt_o | output | NUM_VNET*CNT_W | Buffer read counters per virtual network |

## Verification
The assertions assume well-behaved neighbours. The upstream sender never offers a flit to a VC whose buffer is full unless that VC is being popped in the same cycle. The allocator grants only a VC whose head is valid and ready. The stimulus keeps to both by sending at most three flits into a VC before draining it, and by granting a VC only after waiting out the full pipeline delay. Protocol violations on the link are not assumed away: the bench drives them on purpose to check the error pulse and the dropping of the flit.

// File: rtl/vcin_pkg.sv
package vcin_pkg;

    typedef enum logic [1:0] {
        FK_OPEN   = 2'd0,
        FK_MID    = 2'd1,
        FK_CLOSE  = 2'd2,
        FK_SINGLE = 2'd3
    } flit_kind_e;

    // Kinds that start a packet and claim an idle VC
    function automatic logic kind_opens(input logic [1:0] k);
        return (k == FK_OPEN) || (k == FK_SINGLE);
    endfunction

    // Kinds that end a packet and release the VC on departure
    function automatic logic kind_closes(input logic [1:0] k);
        return (k == FK_CLOSE) || (k == FK_SINGLE);
    endfunction

endpackage

// File: rtl/vcin_vc_buf.sv
module vcin_vc_buf #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 16,
    parameter int PIPE   = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_kind_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic              head_vld_o,
    output logic              head_rdy_o,
    output logic [1:0]        head_kind_o,
    output logic [DATA_W-1:0] head_data_o,
    output logic              full_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int AGE_W = (PIPE > 1) ? $clog2(PIPE) : 1;
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(PIPE - 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][1:0]        kind;
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [DEPTH-1:0][AGE_W-1:0]  age;
        logic [DEPTH-1:0]             occ;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
    } buf_s;

    buf_s buf_d, buf_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        buf_d = buf_q;
        // Every occupied slot ages by one cycle, saturating at the wait limit
        for (int i = 0; i < DEPTH; i++) begin
            if (buf_q.occ[i] && (buf_q.age[i] != AGE_MAX))
                buf_d.age[i] = buf_q.age[i] + 1'b1;
        end
        if (rd_en_i && buf_q.occ[buf_q.rd]) begin
            buf_d.occ[buf_q.rd] = 1'b0;
            buf_d.rd            = ptr_inc(buf_q.rd);
        end
        if (wr_en_i) begin
            buf_d.kind[buf_q.wr] = wr_kind_i;
            buf_d.data[buf_q.wr] = wr_data_i;
            buf_d.age[buf_q.wr]  = '0;
            buf_d.occ[buf_q.wr]  = 1'b1;
            buf_d.wr             = ptr_inc(buf_q.wr);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) buf_q <= '0;
        else       buf_q <= buf_d;
    end

    assign head_vld_o  = buf_q.occ[buf_q.rd];
    assign head_rdy_o  = buf_q.occ[buf_q.rd] && (buf_q.age[buf_q.rd] == AGE_MAX);
    assign head_kind_o = buf_q.kind[buf_q.rd];
    assign head_data_o = buf_q.data[buf_q.rd];
    assign full_o      = &buf_q.occ;

    // R6: a pop is only requested when something is there to pop
    p_pop_nonempty_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_en_i |-> head_vld_o);

    // R4: a flit entering an empty buffer is visible next cycle
    p_fresh_visible_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && !head_vld_o) |=> head_vld_o);

    generate
        if (PIPE > 1) begin : g_wait_chk
            // R4: with a multi-stage pipe, a fresh flit is never ready at once
            p_fresh_not_ready_r4: assert property (@(posedge clk_i) disable iff (rst_i)
                (wr_en_i && !head_vld_o) |=> !head_rdy_o);
        end
    endgenerate

endmodule

// File: rtl/vcin_vnet_stats.sv
module vcin_vnet_stats #(
    parameter int NUM_VNET = 2,
    parameter int CNT_W    = 16
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      clr_i,
    input  logic                      inc_en_i,
    input  logic [VN_W-1:0]           inc_vnet_i,
    output logic [NUM_VNET*CNT_W-1:0] wr_cnt_o,
    output logic [NUM_VNET*CNT_W-1:0] rd_cnt_o
);

    localparam int VN_W = (NUM_VNET > 1) ? $clog2(NUM_VNET) : 1;

    typedef struct packed {
        logic [NUM_VNET-1:0][CNT_W-1:0] wr;
        logic [NUM_VNET-1:0][CNT_W-1:0] rd;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_en_i) begin
            cnt_d.wr[inc_vnet_i] = cnt_q.wr[inc_vnet_i] + 1'b1;
            cnt_d.rd[inc_vnet_i] = cnt_q.rd[inc_vnet_i] + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign wr_cnt_o = cnt_q.wr;
    assign rd_cnt_o = cnt_q.rd;

    // R9: a clear request empties every counter at the next edge
    p_clear_zero_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (wr_cnt_o == '0) && (rd_cnt_o == '0));

    // R8: counters move only on an accepted flit
    p_quiet_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!clr_i && !inc_en_i) |=> ($stable(wr_cnt_o) && $stable(rd_cnt_o)));

endmodule

// File: rtl/vcin_input_unit.sv
module vcin_input_unit
    import vcin_pkg::*;
#(
    parameter int NUM_VC      = 4,
    parameter int VC_PER_VNET = 2,
    parameter int DEPTH       = 4,
    parameter int PIPE        = 3,
    parameter int DATA_W      = 16,
    parameter int DEST_W      = 4,
    parameter int OP_W        = 3,
    parameter int CNT_W       = 16,
    localparam int VC_W       = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    localparam int NUM_VNET   = NUM_VC / VC_PER_VNET
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      in_vld_i,
    input  logic [VC_W-1:0]           in_vc_i,
    input  logic [1:0]                in_type_i,
    input  logic [DEST_W-1:0]         in_dest_i,
    input  logic [DATA_W-1:0]         in_data_i,
    output logic [DEST_W-1:0]         rc_dest_o,
    input  logic [OP_W-1:0]           rc_outport_i,
    output logic [NUM_VC-1:0]         vc_head_vld_o,
    output logic [NUM_VC-1:0]         vc_head_rdy_o,
    output logic [NUM_VC*OP_W-1:0]    vc_outport_o,
    output logic [NUM_VC*2-1:0]       vc_head_type_o,
    output logic [NUM_VC*DATA_W-1:0]  vc_head_data_o,
    input  logic                      sa_gnt_vld_i,
    input  logic [VC_W-1:0]           sa_gnt_vc_i,
    output logic                      crd_vld_o,
    output logic [VC_W-1:0]           crd_vc_o,
    output logic                      crd_free_o,
    output logic                      proto_err_o,
    input  logic                      stats_clr_i,
    output logic [NUM_VNET*CNT_W-1:0] buf_wr_cnt_o,
    output logic [NUM_VNET*CNT_W-1:0] buf_rd_cnt_o
);

    localparam int VN_W = (NUM_VNET > 1) ? $clog2(NUM_VNET) : 1;

    typedef struct packed {
        logic [NUM_VC-1:0]           act;
        logic [NUM_VC-1:0][OP_W-1:0] oport;
        logic                        crd_vld;
        logic [VC_W-1:0]             crd_vc;
        logic                        crd_free;
        logic                        err;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic [NUM_VC-1:0][1:0]        head_kind;
    logic [NUM_VC-1:0][DATA_W-1:0] head_data;
    logic [NUM_VC-1:0]             buf_full;
    logic [NUM_VC-1:0]             wr_en;
    logic [NUM_VC-1:0]             rd_en;
    logic                          in_opens;
    logic                          in_legal;
    logic                          in_accept;
    logic [VN_W-1:0]               in_vnet;

    // Route stub: destination goes straight to the external route function
    assign rc_dest_o = in_dest_i;

    always_comb begin
        in_opens  = kind_opens(in_type_i);
        in_legal  = in_opens ? !ctl_q.act[in_vc_i] : ctl_q.act[in_vc_i];
        in_accept = in_vld_i && in_legal;
        in_vnet   = VN_W'(int'(in_vc_i) / VC_PER_VNET);
        for (int v = 0; v < NUM_VC; v++) begin
            wr_en[v] = in_accept && (in_vc_i == VC_W'(v));
            rd_en[v] = sa_gnt_vld_i && (sa_gnt_vc_i == VC_W'(v));
        end
    end

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.err      = in_vld_i && !in_legal;
        ctl_d.crd_vld  = sa_gnt_vld_i;
        ctl_d.crd_vc   = sa_gnt_vld_i ? sa_gnt_vc_i : '0;
        ctl_d.crd_free = sa_gnt_vld_i && kind_closes(head_kind[sa_gnt_vc_i]);
        if (sa_gnt_vld_i && kind_closes(head_kind[sa_gnt_vc_i]))
            ctl_d.act[sa_gnt_vc_i] = 1'b0;
        if (in_accept && in_opens) begin
            ctl_d.act[in_vc_i]   = 1'b1;
            ctl_d.oport[in_vc_i] = rc_outport_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ctl_q <= '0;
        else       ctl_q <= ctl_d;
    end

    generate
        for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
            vcin_vc_buf #(
                .DEPTH  (DEPTH),
                .DATA_W (DATA_W),
                .PIPE   (PIPE)
            ) u_buf (
                .clk_i       (clk_i),
                .rst_i       (rst_i),
                .wr_en_i     (wr_en[g]),
                .wr_kind_i   (in_type_i),
                .wr_data_i   (in_data_i),
                .rd_en_i     (rd_en[g]),
                .head_vld_o  (vc_head_vld_o[g]),
                .head_rdy_o  (vc_head_rdy_o[g]),
                .head_kind_o (head_kind[g]),
                .head_data_o (head_data[g]),
                .full_o      (buf_full[g])
            );
        end
    endgenerate

    vcin_vnet_stats #(
        .NUM_VNET (NUM_VNET),
        .CNT_W    (CNT_W)
    ) u_stats (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .clr_i      (stats_clr_i),
        .inc_en_i   (in_accept),
        .inc_vnet_i (in_vnet),
        .wr_cnt_o   (buf_wr_cnt_o),
        .rd_cnt_o   (buf_rd_cnt_o)
    );

    assign vc_outport_o   = ctl_q.oport;
    assign vc_head_type_o = head_kind;
    assign vc_head_data_o = head_data;
    assign crd_vld_o      = ctl_q.crd_vld;
    assign crd_vc_o       = ctl_q.crd_vc;
    assign crd_free_o     = ctl_q.crd_free;
    assign proto_err_o    = ctl_q.err;

    // R3: the sender respects buffer space (input assumption)
    p_room_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        in_vld_i |-> (!buf_full[in_vc_i] || (sa_gnt_vld_i && sa_gnt_vc_i == in_vc_i)));

    // R6: the allocator grants only a ready head (input assumption)
    p_gnt_ready_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        sa_gnt_vld_i |-> vc_head_rdy_o[sa_gnt_vc_i]);

    // R6: a grant is answered by a credit for the same VC one edge later
    p_crd_next_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        sa_gnt_vld_i |=> (crd_vld_o && crd_vc_o == $past(sa_gnt_vc_i)));

    // R6: no credit without a grant
    p_crd_idle_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !sa_gnt_vld_i |=> !crd_vld_o);

    // R2: latched output ports only change on link activity
    p_oport_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_vld_i |=> $stable(vc_outport_o));

    // R5: with no flit offered there is no error pulse
    p_err_needs_flit_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_vld_i |=> !proto_err_o);

endmodule

// File: tb/vcin_input_unit_bench.sv
module vcin_input_unit_bench;
    import vcin_pkg::*;

    localparam int NV = 4, VPN = 2, DEP = 4, PIPE = 3;
    localparam int DW = 16, DSW = 4, OPW = 3, CW = 16, NVN = NV / VPN;

    logic clk = 1'b0, rst = 1'b1;
    logic in_vld = 1'b0;
    logic [1:0] in_vc = '0, in_type = '0;
    logic [DSW-1:0] in_dest = '0;
    logic [DW-1:0] in_data = '0;
    logic [DSW-1:0] rc_dest;
    logic [OPW-1:0] rc_outport;
    logic [NV-1:0] head_vld, head_rdy;
    logic [NV*OPW-1:0] outport;
    logic [NV*2-1:0] head_type;
    logic [NV*DW-1:0] head_data;
    logic gnt_vld = 1'b0;
    logic [1:0] gnt_vc = '0;
    logic crd_vld, crd_free, perr;
    logic [1:0] crd_vc;
    logic clr = 1'b0;
    logic [NVN*CW-1:0] wr_cnt, rd_cnt;

    int total = 0, bad = 0;
    int exp_cnt [NVN];

    always #10 clk = ~clk;

    function automatic logic [OPW-1:0] route_of(input logic [DSW-1:0] d);
        return d[2:0] + 3'd1;
    endfunction
    assign rc_outport = route_of(rc_dest);

    vcin_input_unit #(.NUM_VC(NV), .VC_PER_VNET(VPN), .DEPTH(DEP), .PIPE(PIPE),
        .DATA_W(DW), .DEST_W(DSW), .OP_W(OPW), .CNT_W(CW)) u_vcin_input_unit (
        .clk_i(clk), .rst_i(rst), .in_vld_i(in_vld), .in_vc_i(in_vc),
        .in_type_i(in_type), .in_dest_i(in_dest), .in_data_i(in_data),
        .rc_dest_o(rc_dest), .rc_outport_i(rc_outport),
        .vc_head_vld_o(head_vld), .vc_head_rdy_o(head_rdy), .vc_outport_o(outport),
        .vc_head_type_o(head_type), .vc_head_data_o(head_data),
        .sa_gnt_vld_i(gnt_vld), .sa_gnt_vc_i(gnt_vc),
        .crd_vld_o(crd_vld), .crd_vc_o(crd_vc), .crd_free_o(crd_free),
        .proto_err_o(perr), .stats_clr_i(clr),
        .buf_wr_cnt_o(wr_cnt), .buf_rd_cnt_o(rd_cnt));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int vc, input int kind, input int dest, input int data);
        in_vld = 1'b1; in_vc = 2'(vc); in_type = 2'(kind);
        in_dest = DSW'(dest); in_data = DW'(data);
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic drain_one(input int vc, input int kind, input int data);
        chk("R4 head ready", int'(head_rdy[vc]), 1);
        chk("R3 head kind", int'(head_type[vc*2 +: 2]), kind);
        chk("R3 head data", int'(head_data[vc*DW +: DW]), data);
        gnt_vld = 1'b1; gnt_vc = 2'(vc);
        @(negedge clk);
        gnt_vld = 1'b0;
        chk("R6 credit valid", int'(crd_vld), 1);
        chk("R6 credit vc", int'(crd_vc), vc);
        chk("R6 credit free", int'(crd_free), int'(kind_closes(2'(kind))));
    endtask

    task automatic chk_counters(input string req);
        for (int n = 0; n < NVN; n++) begin
            chk(req, int'(wr_cnt[n*CW +: CW]), exp_cnt[n]);
            chk(req, int'(rd_cnt[n*CW +: CW]), exp_cnt[n]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int n = 0; n < NVN; n++) exp_cnt[n] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 no head", int'(head_vld), 0);
        chk("R1 no credit", int'(crd_vld), 0);
        chk("R1 no error", int'(perr), 0);
        chk_counters("R1 counters zero");

        // R4: pipeline wait of a single-flit packet on VC1
        send(1, FK_SINGLE, 5, 16'h1234);
        exp_cnt[0]++;
        for (int j = 0; j <= PIPE; j++) begin
            chk("R4 head valid", int'(head_vld[1]), 1);
            chk("R4 ready timing", int'(head_rdy[1]), (j >= PIPE - 1) ? 1 : 0);
            if (j < PIPE) @(negedge clk);
        end
        chk("R2 route latched", int'(outport[1*OPW +: OPW]), int'(route_of(4'd5)));
        drain_one(1, FK_SINGLE, 16'h1234);
        chk("R6 popped", int'(head_vld[1]), 0);
        @(negedge clk);
        chk("R6 credit idle", int'(crd_vld), 0);

        // R2 R3 R6 R7 R8: sweep every VC and packet lengths 1..3
        for (int vc = 0; vc < NV; vc++) begin
            for (int len = 1; len <= 3; len++) begin
                int first_dest;
                first_dest = (vc * 3 + len) & 15;
                for (int k = 0; k < len; k++) begin
                    int kind;
                    kind = (len == 1) ? FK_SINGLE : (k == 0) ? FK_OPEN :
                           (k == len - 1) ? FK_CLOSE : FK_MID;
                    send(vc, kind, (first_dest + 5 * k) & 15, vc * 256 + len * 16 + k);
                    chk("R5 no error", int'(perr), 0);
                end
                chk("R2 route held", int'(outport[vc*OPW +: OPW]),
                    int'(route_of(DSW'(first_dest))));
                exp_cnt[vc / VPN] += len;
                repeat (PIPE) @(negedge clk);
                for (int k = 0; k < len; k++) begin
                    int kind;
                    kind = (len == 1) ? FK_SINGLE : (k == 0) ? FK_OPEN :
                           (k == len - 1) ? FK_CLOSE : FK_MID;
                    drain_one(vc, kind, vc * 256 + len * 16 + k);
                end
                chk("R7 vc empty", int'(head_vld[vc]), 0);
            end
        end
        chk_counters("R8 per-vnet counts");

        // R3: interleaved packets on VC0 and VC3
        send(0, FK_OPEN, 2, 16'hA0);
        send(3, FK_OPEN, 9, 16'hB0);
        send(0, FK_CLOSE, 7, 16'hA1);
        send(3, FK_MID, 1, 16'hB1);
        send(3, FK_CLOSE, 4, 16'hB2);
        exp_cnt[0] += 2; exp_cnt[1] += 3;
        chk("R2 vc0 route", int'(outport[0 +: OPW]), int'(route_of(4'd2)));
        chk("R2 vc3 route", int'(outport[3*OPW +: OPW]), int'(route_of(4'd9)));
        repeat (PIPE) @(negedge clk);
        drain_one(3, FK_OPEN, 16'hB0);
        drain_one(3, FK_MID, 16'hB1);
        drain_one(3, FK_CLOSE, 16'hB2);
        drain_one(0, FK_OPEN, 16'hA0);
        drain_one(0, FK_CLOSE, 16'hA1);
        chk_counters("R8 after interleave");

        // R5: continuation kinds on an idle VC
        for (int kind = FK_MID; kind <= FK_CLOSE; kind++) begin
            send(2, kind, 3, 16'hDEAD);
            chk("R5 error pulse", int'(perr), 1);
            chk("R5 not buffered", int'(head_vld[2]), 0);
            @(negedge clk);
            chk("R5 pulse one cycle", int'(perr), 0);
        end
        chk_counters("R5 not counted");

        // R5: second opening flit on a busy VC
        send(0, FK_OPEN, 6, 16'hC0);
        send(0, FK_OPEN, 1, 16'hC9);
        chk("R5 error on busy", int'(perr), 1);
        chk("R5 route kept", int'(outport[0 +: OPW]), int'(route_of(4'd6)));
        send(0, FK_CLOSE, 0, 16'hC1);
        chk("R5 legal close", int'(perr), 0);
        exp_cnt[0] += 2;
        repeat (PIPE) @(negedge clk);
        drain_one(0, FK_OPEN, 16'hC0);
        drain_one(0, FK_CLOSE, 16'hC1);
        chk("R5 dropped flit absent", int'(head_vld[0]), 0);

        // R7: VC0 is idle again
        send(0, FK_MID, 0, 16'hE0);
        chk("R7 middle on freed vc", int'(perr), 1);
        send(0, FK_SINGLE, 3, 16'hE1);
        chk("R7 open on freed vc", int'(perr), 0);
        exp_cnt[0] += 1;
        repeat (PIPE) @(negedge clk);
        drain_one(0, FK_SINGLE, 16'hE1);
        chk_counters("R8 final counts");

        // R9: clear wins over a same-cycle write; state and buffer survive
        clr = 1'b1;
        send(1, FK_OPEN, 4, 16'hF0);
        clr = 1'b0;
        for (int n = 0; n < NVN; n++) exp_cnt[n] = 0;
        chk_counters("R9 cleared");
        chk("R9 buffer kept", int'(head_vld[1]), 1);
        send(1, FK_CLOSE, 4, 16'hF1);
        chk("R9 vc state kept", int'(perr), 0);
        exp_cnt[0] = 1;
        chk_counters("R9 counting resumes");
        repeat (PIPE) @(negedge clk);
        drain_one(1, FK_OPEN, 16'hF0);
        drain_one(1, FK_CLOSE, 16'hF1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule